// File: doc/BRIEF.md
# Shared Event Interrupt Collector

This block gathers several event pulses from local logic and drives one active-low interrupt line toward a local controller. The events are a read transfer count reaching zero, a write transfer count reaching zero, an error during a bus-master transaction, and a mailbox event. Each event arrives as a one-cycle pulse on its own input bit. The block records the event in a sticky pending bit that stays set until it is cleared.

Because one line serves every source, the controller finds the cause by reading a status word, and it clears sources by writing ones to that same word. A separate enable word chooses which pending sources may pull the line low. The line falls whenever at least one source is both pending and enabled. It rises again once every such source is cleared or disabled.

Top module: `evt_irq_hub`

## Requirements
- R1: After a synchronous reset, every pending bit and enable bit is 0, `irq_n_o` is 1 and `reg_rdata_o` is 0.
- R2: A 1 on `evt_i[k]` sets pending bit k, and the bit stays set over later cycles with no event. The bit positions are: bit 0 for read count zero, bit 1 for write count zero, bit 2 for the bus-master error and bit 3 for the mailbox event.
- R3: A write to address 0 (the status word) clears each pending bit whose write-data bit is 1. Write-data bits that are 0 leave their pending bits unchanged.
- R4: If an event and a clear hit the same bit in the same cycle, the bit stays pending.
- R5: Address 1 holds the enable word. It can be written and read back. Bits at positions NUM_SRC and above always read as 0.
- R6: `irq_n_o` is registered. In each cycle it equals the inverse of the OR of (pending AND enable) as that value stood in the previous cycle. It therefore falls one clock after a source becomes both pending and enabled.
- R7: A source that is pending but disabled still shows in the status word and does not pull `irq_n_o` low. If it is enabled later, the line falls.
- R8: A read (`reg_rd_i` high) returns the word at `reg_addr_i` on `reg_rdata_o` one clock later. `reg_rdata_o` holds its value in cycles with no read.
- R9: Clearing every enabled pending source returns `irq_n_o` to 1 one clock after the clear takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | NUM_SRC | One-cycle event pulses, one bit per source |
| reg_addr_i | input | 1 | Register select: 0 selects status, 1 selects enable |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Registered read data |
| irq_n_o | output | 1 | Shared interrupt line, active low |

## Verification
The hardest case to reach from the ports is an event pulse that lands in the same clock as a write-one-to-clear of the same bit. The bench drives the event input and the status write together on one falling edge, so both are seen at the same rising edge. It then reads the status word to confirm that the bit survived while a neighbouring bit cleared in that same write. Another case is the delayed fall of the line for a source that was already pending while disabled. This is reached by raising events with the enable word at 0, checking that the line stays high, and then writing the enable.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int SRC_RD_ZERO  = 0;
  localparam int SRC_WR_ZERO  = 1;
  localparam int SRC_MST_ERR  = 2;
  localparam int SRC_MAILBOX  = 3;

  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_ENABLE = 1'b1;
endpackage

// File: rtl/evt_pend_bank.sv
module evt_pend_bank #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt,
  input  logic [NUM_SRC-1:0] clr,
  output logic [NUM_SRC-1:0] pend
);
  // One sticky flop per source; a set beats a clear in the same cycle.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)         pend[i] <= 1'b0;
      else if (evt[i]) pend[i] <= 1'b1;
      else if (clr[i]) pend[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_reg_port.sv
module evt_reg_port
  import evt_irq_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               addr,
  input  logic               wr,
  input  logic               rd,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_SRC-1:0] pend,
  output logic [NUM_SRC-1:0] clr,
  output logic [NUM_SRC-1:0] en,
  output logic [DATA_W-1:0]  rdata
);
  logic [DATA_W-1:0] pend_ext;
  logic [DATA_W-1:0] en_ext;

  always_comb begin
    pend_ext = '0;
    en_ext   = '0;
    pend_ext[NUM_SRC-1:0] = pend;
    en_ext[NUM_SRC-1:0]   = en;
  end

  // Write-one-to-clear strobe toward the pending bank.
  always_comb begin
    clr = '0;
    if (wr && addr == ADDR_STATUS) clr = wdata[NUM_SRC-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)                           en <= '0;
    else if (wr && addr == ADDR_ENABLE) en <= wdata[NUM_SRC-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= (addr == ADDR_STATUS) ? pend_ext : en_ext;
  end
endmodule

// File: rtl/evt_irq_merge.sv
module evt_irq_merge #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] en,
  output logic               irq_n
);
  logic any_live;

  assign any_live = |(pend & en);

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~any_live;
  end
endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub #(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               reg_addr_i,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               irq_n_o
);
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] clr_s;

  evt_pend_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk (clk),
    .rst (rst),
    .evt (evt_i),
    .clr (clr_s),
    .pend(pend_q)
  );

  evt_reg_port #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_port (
    .clk  (clk),
    .rst  (rst),
    .addr (reg_addr_i),
    .wr   (reg_wr_i),
    .rd   (reg_rd_i),
    .wdata(reg_wdata_i),
    .pend (pend_q),
    .clr  (clr_s),
    .en   (en_q),
    .rdata(reg_rdata_o)
  );

  evt_irq_merge #(.NUM_SRC(NUM_SRC)) u_merge (
    .clk  (clk),
    .rst  (rst),
    .pend (pend_q),
    .en   (en_q),
    .irq_n(irq_n_o)
  );
endmodule

// File: rtl/evt_irq_hub_chk.sv
module evt_irq_hub_chk #(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               reg_addr_i,
  input logic               reg_wr_i,
  input logic [DATA_W-1:0]  reg_wdata_i,
  input logic               irq_n_o,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC-1:0] en
);
  logic [NUM_SRC-1:0] clr_req;

  always_comb begin
    clr_req = '0;
    if (reg_wr_i && reg_addr_i == 1'b0) clr_req = reg_wdata_i[NUM_SRC-1:0];
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (irq_n_o && pend == '0 && en == '0)); // R1

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & $past(evt_i)) == $past(evt_i))); // R4

  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & $past(pend & ~clr_req)) == $past(pend & ~clr_req))); // R2

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & $past(clr_req & ~evt_i)) == '0)); // R3

  AST_LINE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_n_o == !($past(|(pend & en))))); // R6
endmodule

bind evt_irq_hub evt_irq_hub_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .evt_i      (evt_i),
  .reg_addr_i (reg_addr_i),
  .reg_wr_i   (reg_wr_i),
  .reg_wdata_i(reg_wdata_i),
  .irq_n_o    (irq_n_o),
  .pend       (pend_q),
  .en         (en_q)
);

// File: tb/test_evt_irq_hub.sv
module test_evt_irq_hub;
  localparam int NUM_SRC = 4;
  localparam int DATA_W  = 8;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [NUM_SRC-1:0] evt_i = '0;
  logic               reg_addr_i = 1'b0;
  logic               reg_wr_i = 1'b0;
  logic               reg_rd_i = 1'b0;
  logic [DATA_W-1:0]  reg_wdata_i = '0;
  logic [DATA_W-1:0]  reg_rdata_o;
  logic               irq_n_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  evt_irq_hub #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) i_evt_irq_hub (
    .clk(clk), .rst(rst), .evt_i(evt_i), .reg_addr_i(reg_addr_i),
    .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_n_o(irq_n_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse(input logic [NUM_SRC-1:0] m);
    evt_i = m;
    tick();
    evt_i = '0;
  endtask

  task automatic wr(input logic a, input logic [DATA_W-1:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    tick();
    reg_wr_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd(input logic a, output logic [DATA_W-1:0] d);
    reg_addr_i = a; reg_rd_i = 1'b1;
    tick();
    reg_rd_i = 1'b0;
    d = reg_rdata_o;
  endtask

  task automatic t_reset();
    logic [DATA_W-1:0] d;
    check("R1 irq_n after reset", irq_n_o, 1);
    check("R1 rdata after reset", reg_rdata_o, 0);
    rd(1'b0, d); check("R1 status after reset", d, 0);
    rd(1'b1, d); check("R1 enable after reset", d, 0);
  endtask

  task automatic t_set_sticky();
    logic [DATA_W-1:0] d;
    pulse(4'b0001); tick(); tick();
    rd(1'b0, d); check("R2 read-zero bit0 sticky", d, 8'h01);
    pulse(4'b1000);
    rd(1'b0, d); check("R2 mailbox bit3", d, 8'h09);
    pulse(4'b0100); pulse(4'b0010);
    rd(1'b0, d); check("R2 all four pending", d, 8'h0F);
    check("R7 disabled pending keeps irq high", irq_n_o, 1);
  endtask

  task automatic t_enable();
    logic [DATA_W-1:0] d;
    wr(1'b1, 8'hFF);
    rd(1'b1, d); check("R5 enable readback upper bits zero", d, 8'h0F);
    check("R7 irq low after enabling pending", irq_n_o, 0);
  endtask

  task automatic t_clear();
    logic [DATA_W-1:0] d;
    wr(1'b0, 8'h00);
    rd(1'b0, d); check("R3 zero write leaves status", d, 8'h0F);
    wr(1'b0, 8'h05);
    rd(1'b0, d); check("R3 clear bits 0 and 2", d, 8'h0A);
    check("R9 irq stays low with live sources", irq_n_o, 0);
    wr(1'b0, 8'h0A);
    check("R9 irq still low one clock after clear", irq_n_o, 0);
    tick();
    check("R9 irq released", irq_n_o, 1);
    rd(1'b0, d); check("R3 status empty", d, 8'h00);
  endtask

  task automatic t_collide();
    logic [DATA_W-1:0] d;
    pulse(4'b0001);
    evt_i = 4'b0100; reg_addr_i = 1'b0; reg_wdata_i = 8'h05; reg_wr_i = 1'b1;
    tick();
    evt_i = '0; reg_wr_i = 1'b0; reg_wdata_i = '0;
    rd(1'b0, d); check("R4 event beats clear, neighbour cleared", d, 8'h04);
    wr(1'b0, 8'h04); tick();
  endtask

  task automatic t_mask();
    logic [DATA_W-1:0] d;
    wr(1'b1, 8'h08); tick(); tick();
    check("R9 irq high when none pending", irq_n_o, 1);
    pulse(4'b0001); tick();
    check("R7 masked source leaves irq high", irq_n_o, 1);
    pulse(4'b1000);
    check("R6 irq not yet low in set cycle", irq_n_o, 1);
    tick();
    check("R6 irq low one clock later", irq_n_o, 0);
    rd(1'b0, d); check("R7 masked source visible in status", d, 8'h09);
  endtask

  task automatic t_hold();
    logic [DATA_W-1:0] d;
    rd(1'b1, d); check("R8 read enable word", d, 8'h08);
    pulse(4'b0110); tick();
    check("R8 rdata holds without read", reg_rdata_o, 8'h08);
    rd(1'b0, d); check("R8 fresh status read", d, 8'h0F);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_set_sticky();
    t_enable();
    t_clear();
    t_collide();
    t_mask();
    t_hold();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule